// File: doc/BRIEF.md
# Iterative Integer Divider with HI/LO Result Registers

This block is a multi-cycle integer division unit that keeps its results in two architectural registers, HI and LO. A division command carries a dividend and a divisor together with a choice of signed or unsigned arithmetic. The unit then runs a restoring shift-subtract loop that produces one quotient bit per clock. When the loop ends, the quotient goes into LO and the remainder into HI.

Signed and unsigned division use the same datapath. In signed mode the operands are reduced to their magnitudes before the loop starts, and the signs are applied once, at the end. Four single-cycle move commands connect HI and LO to the outside. Two of them copy a register onto the result port. The other two load a register from operand A.

While a division is running, the unit reports busy. During that time it ignores any new division and any register load.

Top module: `hilo_divider`

## Requirements
- R1: Command code 0x1b divides opA by opB as unsigned 32-bit numbers. At completion LO holds the quotient and HI holds the remainder.
- R2: Command code 0x1a divides as two's-complement numbers. The magnitudes are divided; the quotient is negated when the operand signs differ, and the remainder carries the sign of the dividend. For example, -2^31 / -1 gives LO = 0x80000000 and HI = 0.
- R3: busy rises on the clock edge that accepts a division and falls on the edge 32 cycles later. On that same edge, done rises for exactly one cycle.
- R4: With a zero divisor, in either mode, the division still completes in 32 cycles. It leaves LO = 0xFFFFFFFF and HI equal to the dividend opA.
- R5: Command 0x10 places HI on resultOut, and command 0x12 places LO on resultOut, one clock edge after the command. Both are also honoured while busy, and then return the values held before the division. resultOut holds its value between reads.
- R6: When not busy, command 0x11 loads HI from opA and command 0x13 loads LO from opA, on the accepting edge.
- R7: While busy, a division command or a load command (0x11, 0x13) has no effect. HI and LO change only at completion, and the running division finishes on its original schedule with its original operands.
- R8: After reset, busy = 0, done = 0, resultOut = 0, HI = 0 and LO = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdCode | input | 6 | Command code: 0x1a signed div, 0x1b unsigned div, 0x10/0x12 read HI/LO, 0x11/0x13 load HI/LO |
| opA | input | 32 | Dividend, or the value to load |
| opB | input | 32 | Divisor |
| resultOut | output | 32 | Register holding the last HI or LO read |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when a division commits |

## Verification
The bound checker enforces the following on every cycle:
- the busy window is exactly 32 cycles long, and done is a single pulse at its end;
- HI and LO stay frozen while busy;
- a read shows the register value on the next edge;
- an idle load lands in the addressed register.

Only the bench scenarios can show that the arithmetic is right, because that needs reference quotients and remainders. These scenarios cover:
- the sign rules;
- the most-negative-over-minus-one case;
- zero divisors in both modes;
- a second division issued mid-run, which must not disturb the first result.

// File: rtl/hilo_div_pkg.sv
`timescale 1ns/1ps
package hilo_div_pkg;
  localparam int CODE_W = 6;

  localparam logic [CODE_W-1:0] FN_MFHI = 6'h10;
  localparam logic [CODE_W-1:0] FN_MTHI = 6'h11;
  localparam logic [CODE_W-1:0] FN_MFLO = 6'h12;
  localparam logic [CODE_W-1:0] FN_MTLO = 6'h13;
  localparam logic [CODE_W-1:0] FN_DIVS = 6'h1a;
  localparam logic [CODE_W-1:0] FN_DIVU = 6'h1b;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadOps;   // capture operands, start a division
    logic signedOp;  // qualifies loadOps
    logic step;      // one shift-subtract iteration
    logic commit;    // final iteration, write HI/LO
    logic writeHi;
    logic writeLo;
    logic readHi;
    logic readLo;
  } divStrobes_t;
endpackage

// File: rtl/hilo_div_ctrl.sv
`timescale 1ns/1ps
module hilo_div_ctrl
  import hilo_div_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CODE_W-1:0] cmdCode,
  output divStrobes_t       strobes,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  logic             busyR;
  logic             doneR;
  logic [CNT_W-1:0] stepCnt;
  logic             idleCmd;
  logic             isDiv;

  assign idleCmd = cmdValid && !busyR;
  assign isDiv   = (cmdCode == FN_DIVS) || (cmdCode == FN_DIVU);

  always_comb begin
    strobes          = '0;
    strobes.loadOps  = idleCmd && isDiv;
    strobes.signedOp = (cmdCode == FN_DIVS);
    strobes.step     = busyR;
    strobes.commit   = busyR && (stepCnt == LAST_STEP);
    strobes.writeHi  = idleCmd && (cmdCode == FN_MTHI);
    strobes.writeLo  = idleCmd && (cmdCode == FN_MTLO);
    strobes.readHi   = cmdValid && (cmdCode == FN_MFHI);
    strobes.readLo   = cmdValid && (cmdCode == FN_MFLO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR   <= 1'b0;
      doneR   <= 1'b0;
      stepCnt <= '0;
    end else begin
      doneR <= strobes.commit;
      if (strobes.loadOps) begin
        busyR   <= 1'b1;
        stepCnt <= '0;
      end else if (strobes.commit) begin
        busyR   <= 1'b0;
        stepCnt <= '0;
      end else if (busyR) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign busy = busyR;
  assign done = doneR;
endmodule

// File: rtl/hilo_div_datapath.sv
`timescale 1ns/1ps
module hilo_div_datapath
  import hilo_div_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobes_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] hiVal,
  output logic [DATA_W-1:0] loVal
);
  logic [DATA_W-1:0] divisorR, remR, quoR, hiR, loR, resR;
  logic              negQuoR, negRemR;

  logic              aNeg, bNeg;
  logic [DATA_W-1:0] aMag, bMag;
  logic [DATA_W:0]   shifted;
  logic [DATA_W-1:0] diff, nextRem, nextQuo, quoFinal, remFinal;
  logic              borrow;

  // Operand magnitudes for the signed variant
  assign aNeg = strobes.signedOp && opA[DATA_W-1];
  assign bNeg = strobes.signedOp && opB[DATA_W-1];
  assign aMag = aNeg ? (~opA + 1'b1) : opA;
  assign bMag = bNeg ? (~opB + 1'b1) : opB;

  // One restoring iteration; the remainder always stays below the divisor,
  // so a modular DATA_W-bit difference is exact when no borrow occurs
  assign shifted = {remR, quoR[DATA_W-1]};
  assign borrow  = shifted < {1'b0, divisorR};
  assign diff    = shifted[DATA_W-1:0] - divisorR;
  assign nextRem = borrow ? shifted[DATA_W-1:0] : diff;
  assign nextQuo = {quoR[DATA_W-2:0], ~borrow};

  assign quoFinal = negQuoR ? (~nextQuo + 1'b1) : nextQuo;
  assign remFinal = negRemR ? (~nextRem + 1'b1) : nextRem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisorR <= '0;
      remR     <= '0;
      quoR     <= '0;
      negQuoR  <= 1'b0;
      negRemR  <= 1'b0;
    end else if (strobes.loadOps) begin
      divisorR <= bMag;
      remR     <= '0;
      quoR     <= aMag;
      // a zero divisor keeps the all-ones quotient unsigned
      negQuoR  <= (aNeg ^ bNeg) && (opB != '0);
      negRemR  <= aNeg;
    end else if (strobes.step) begin
      remR <= nextRem;
      quoR <= nextQuo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiR <= '0;
      loR <= '0;
    end else if (strobes.commit) begin
      hiR <= remFinal;
      loR <= quoFinal;
    end else begin
      if (strobes.writeHi) hiR <= opA;
      if (strobes.writeLo) loR <= opA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               resR <= '0;
    else if (strobes.readHi) resR <= hiR;
    else if (strobes.readLo) resR <= loR;
  end

  assign resultOut = resR;
  assign hiVal     = hiR;
  assign loVal     = loR;
endmodule

// File: rtl/hilo_divider.sv
`timescale 1ns/1ps
module hilo_divider
  import hilo_div_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resultOut,
  output logic              busy,
  output logic              done
);
  divStrobes_t       strobes;
  logic [DATA_W-1:0] hiVal, loVal;

  hilo_div_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  hilo_div_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .resultOut (resultOut),
    .hiVal     (hiVal),
    .loVal     (loVal)
  );
endmodule

// File: rtl/hilo_divider_chk.sv
`timescale 1ns/1ps
module hilo_divider_chk
  import hilo_div_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [CODE_W-1:0] cmdCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] resultOut,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] hiVal,
  input logic [DATA_W-1:0] loVal
);
  localparam int CNT_W = $clog2(DATA_W) + 2;

  logic [CNT_W-1:0] busyCnt;
  logic             divCmd;

  assign divCmd = cmdValid && ((cmdCode == FN_DIVS) || (cmdCode == FN_DIVU));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  assert_busy_on_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (divCmd && !busy) |=> busy);

  assert_done_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && busyCnt == CNT_W'(DATA_W)));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hilo_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(hiVal) && $stable(loVal)));

  assert_read_hi_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == FN_MFHI) |=> (resultOut == $past(hiVal)));

  assert_read_lo_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == FN_MFLO) |=> (resultOut == $past(loVal)));

  assert_load_hi_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdCode == FN_MTHI) |=> (hiVal == $past(opA)));

  assert_load_lo_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdCode == FN_MTLO) |=> (loVal == $past(opA)));
endmodule

bind hilo_divider hilo_divider_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdCode   (cmdCode),
  .opA       (opA),
  .resultOut (resultOut),
  .busy      (busy),
  .done      (done),
  .hiVal     (hiVal),
  .loVal     (loVal)
);

// File: tb/tb_hilo_divider.sv
`timescale 1ns/1ps
module tb_hilo_divider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [5:0]  cmdCode = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] resultOut;
  logic        busy, done;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  hilo_divider dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .opA(opA), .opB(opB), .resultOut(resultOut), .busy(busy), .done(done)
  );

  // {signed, dividend, divisor}
  localparam int NV = 11;
  localparam logic [64:0] VECS [NV] = '{
    {1'b0, 32'd100,        32'd7},
    {1'b0, 32'hFFFFFFFF,   32'd3},
    {1'b0, 32'h80000000,   32'hFFFFFFFF},
    {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF},
    {1'b0, 32'd5,          32'd0},
    {1'b1, 32'hFFFFFFF9,   32'd2},
    {1'b1, 32'd7,          32'hFFFFFFFE},
    {1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE},
    {1'b1, 32'h80000000,   32'hFFFFFFFF},
    {1'b1, 32'hFFFFFFF7,   32'd0},
    {1'b1, 32'd12345678,   32'd1000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model built from R1, R2, R4
  function automatic logic [63:0] refDiv(input logic sgn, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    if (b == 0) return {a, 32'hFFFFFFFF};
    if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
    end else begin
      sa = longint'({32'd0, a});
      sb = longint'({32'd0, b});
    end
    q = sa / sb;
    r = sa % sb;
    return {r[31:0], q[31:0]};
  endfunction

  task automatic readReg(input logic [5:0] code, output logic [31:0] val);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    val = resultOut;
  endtask

  task automatic writeReg(input logic [5:0] code, input logic [31:0] val);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code; opA = val;
    @(posedge clk); #1;
    cmdValid = 1'b0;
  endtask

  task automatic doDiv(input logic sgn, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = sgn ? 6'h1a : 6'h1b; opA = a; opB = b;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    check("R3 busy after accept", {31'd0, busy}, 32'd1);
    repeat (31) @(posedge clk);
    #1 check("R3 no done before cycle 32", {31'd0, done}, 32'd0);
    @(posedge clk); #1;
    check("R3 done at cycle 32", {31'd0, done}, 32'd1);
    check("R3 busy low at done", {31'd0, busy}, 32'd0);
    @(posedge clk); #1;
    check("R3 done single pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    logic [63:0] exp;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check("R8 busy reset", {31'd0, busy}, 32'd0);
    check("R8 done reset", {31'd0, done}, 32'd0);
    check("R8 resultOut reset", resultOut, 32'd0);
    readReg(6'h10, v); check("R8 HI reset", v, 32'd0);
    readReg(6'h12, v); check("R8 LO reset", v, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic sg;
      logic [31:0] a, b;
      {sg, a, b} = VECS[i];
      doDiv(sg, a, b);
      exp = refDiv(sg, a, b);
      readReg(6'h12, v);
      check(b == 0 ? "R4 LO zero divisor" : (sg ? "R2 signed LO" : "R1 unsigned LO"), v, exp[31:0]);
      readReg(6'h10, v);
      check(b == 0 ? "R4 HI zero divisor" : (sg ? "R2 signed HI" : "R1 unsigned HI"), v, exp[63:32]);
    end

    // R6 loads, R5 reads and hold
    writeReg(6'h11, 32'h13579BDF);
    writeReg(6'h13, 32'h2468ACE0);
    readReg(6'h10, v); check("R6 load HI", v, 32'h13579BDF);
    readReg(6'h12, v); check("R6 load LO", v, 32'h2468ACE0);
    @(posedge clk); #1 check("R5 resultOut holds", resultOut, 32'h2468ACE0);

    // R7: commands while busy
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 6'h1b; opA = 32'd100; opB = 32'd7;
    @(posedge clk); #1 cmdValid = 1'b0;           // E0
    repeat (8) @(posedge clk);                     // E8
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 6'h11; opA = 32'hDEADBEEF;
    @(posedge clk);                                // E9
    @(negedge clk);
    cmdCode = 6'h10;
    @(posedge clk); #1;                            // E10
    check("R7 load HI ignored while busy", resultOut, 32'h13579BDF);
    @(negedge clk);
    cmdCode = 6'h1a; opA = 32'd5; opB = 32'hFFFFFFFF;
    @(posedge clk); #1 cmdValid = 1'b0;            // E11
    repeat (20) @(posedge clk);                    // E31
    #1 check("R7 no early or late restart", {31'd0, done}, 32'd0);
    @(posedge clk); #1;                            // E32
    check("R7 original schedule kept", {31'd0, done}, 32'd1);
    readReg(6'h12, v); check("R7 LO from first division", v, 32'd14);
    readReg(6'h10, v); check("R7 HI from first division", v, 32'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog R3 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule